// File: doc/BRIEF.md
# Single-Action Output Compare Channel

This block is one timer channel that watches a shared time-base counter bus. When the counter equals a programmed compare value, the channel acts on its output pin. The host never writes the compare value that is in use directly. Its writes land in a staging register. The staged value is promoted into the active compare register only while an update-enable control is high, so a new compare point can be prepared without disturbing the one currently armed.

On every match the channel raises an event flag, which stays high until the host clears it. It also acts on the output flip-flop. One mode forces the pin to a programmed level. The other mode inverts the pin, and in that mode the programmed level plays no part. The pin itself is the readable state of the output flip-flop. Counter generation and all other channel modes live outside this block.

Top module: `soc_cmp_channel`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `flag` and `pin_out` are 0. The active and staging compare registers reset to 0.
- R2: A match is the condition `cnt_bus` equals the active compare value. A match sampled at a rising clock edge makes `flag` 1 after that edge.
- R3: Every match sets the flag again, including each return of a free-running counter to the same value after the flag was cleared.
- R4: With `edge_sel` = 0, a match loads the value of `edge_pol` into `pin_out` at that edge.
- R5: With `edge_sel` = 1, a match inverts `pin_out` at that edge, whatever the value of `edge_pol`.
- R6: A write (`wr_en` = 1) stores `wr_data` only in the staging register. While `upd_en` = 0 the active compare value does not change, so matches keep occurring at the old value and never at the newly written one.
- R7: While `upd_en` = 1, the staging register is copied to the active register at each edge. A value written at edge k is used for matching from the cycle after edge k+1.
- R8: `flag` stays 1 until `flag_clr` = 1 is sampled without a match. When a clear and a match are sampled at the same edge, `flag` stays 1.
- R9: At an edge with no match, `pin_out` keeps its value in both modes, whatever `edge_pol` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_bus | input | CNT_W | Selected time-base counter value |
| wr_en | input | 1 | Host write strobe for the compare value |
| wr_data | input | CNT_W | Compare value written into staging |
| upd_en | input | 1 | Permits staging-to-active transfer |
| edge_sel | input | 1 | Match action: 0 force level, 1 toggle |
| edge_pol | input | 1 | Level forced onto the pin when edge_sel is 0 |
| flag_clr | input | 1 | Write-1 clear of the event flag |
| flag | output | 1 | Match event flag |
| pin_out | output | 1 | Output flip-flop state, also its status readback |

## Verification
The bench builds the channel with a 4-bit counter bus and the bitwise comparator variant. At that width, every compare value can be crossed against every counter value in both match modes. Under that setting, a free-running counter laps many times in a few hundred cycles. Repeated matches, deferred promotion of a staged value, and clear-versus-match collisions therefore all occur with counts small enough that the bench can predict every cycle.

// File: rtl/soc_cmp_pkg.sv
package soc_cmp_pkg;

   typedef enum logic {
      ACT_FORCE  = 1'b0,
      ACT_TOGGLE = 1'b1
   } match_act_e;

   localparam int unsigned CMP_W_MAX = 32;

endpackage

// File: rtl/cmp_stage_buf.sv
module cmp_stage_buf #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         upd_en,
   output logic [W-1:0] active_o
);

   logic [W-1:0] staging_q;
   logic [W-1:0] active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staging_q <= '0;
      end else if (wr_en) begin
         staging_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= '0;
      end else if (upd_en) begin
         active_q <= staging_q;
      end
   end

   assign active_o = active_q;

   // R6: active value frozen while promotion is disabled
   p_act_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(active_q));

   // R7: promotion copies the previously staged value
   p_act_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> active_q == $past(staging_q));

endmodule

// File: rtl/cmp_match_det.sv
module cmp_match_det #(
   parameter int unsigned W     = 16,
   parameter int unsigned STYLE = 0
) (
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] active,
   output logic         hit
);

   generate
      if (STYLE == 0) begin : g_plain
         assign hit = (cnt == active);
      end else begin : g_bitwise
         logic [W-1:0] same;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign same[i] = ~(cnt[i] ^ active[i]);
         end
         assign hit = &same;
      end
   endgenerate

endmodule

// File: rtl/cmp_flag_reg.sv
module cmp_flag_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic clr,
   output logic flag
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (hit) begin
         flag_q <= 1'b1;
      end else if (clr) begin
         flag_q <= 1'b0;
      end
   end

   assign flag = flag_q;

   // R2: each match raises the flag, a simultaneous clear does not win
   p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag_q);

   // R8: without a clear the flag is sticky
   p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q && !clr |=> flag_q);

   // R8: clear without a match drops the flag
   p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !hit |=> !flag_q);

endmodule

// File: rtl/cmp_out_ff.sv
module cmp_out_ff
   import soc_cmp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hit,
   input  match_act_e act,
   input  logic       lvl,
   output logic       pin
);

   logic pin_q;
   logic pin_d;

   always_comb begin
      pin_d = pin_q;
      if (hit) begin
         unique case (act)
            ACT_FORCE:  pin_d = lvl;
            ACT_TOGGLE: pin_d = ~pin_q;
            default:    pin_d = pin_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= 1'b0;
      end else begin
         pin_q <= pin_d;
      end
   end

   assign pin = pin_q;

   // R4: force mode copies the programmed level
   p_pin_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hit && act == ACT_FORCE |=> pin_q == $past(lvl));

   // R5: toggle mode inverts the pin
   p_pin_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit && act == ACT_TOGGLE |=> pin_q != $past(pin_q));

   // R9: no match, no change
   p_pin_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(pin_q));

endmodule

// File: rtl/soc_cmp_channel.sv
module soc_cmp_channel
   import soc_cmp_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned MATCH_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_bus,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             upd_en,
   input  logic             edge_sel,
   input  logic             edge_pol,
   input  logic             flag_clr,
   output logic             flag,
   output logic             pin_out
);

   localparam int unsigned CW = CNT_W;

   generate
      if (CNT_W < 1 || CNT_W > CMP_W_MAX) begin : g_bad_width
         $error("soc_cmp_channel: CNT_W out of range");
      end
      if (MATCH_STYLE > 1) begin : g_bad_style
         $error("soc_cmp_channel: MATCH_STYLE must be 0 or 1");
      end
   endgenerate

   logic [CW-1:0] active_cmp;
   logic          hit;
   match_act_e    act_mode;

   assign act_mode = match_act_e'(edge_sel);

   cmp_stage_buf #(.W(CW)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .upd_en   (upd_en),
      .active_o (active_cmp)
   );

   cmp_match_det #(.W(CW), .STYLE(MATCH_STYLE)) u_det (
      .cnt    (cnt_bus),
      .active (active_cmp),
      .hit    (hit)
   );

   cmp_flag_reg u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit),
      .clr   (flag_clr),
      .flag  (flag)
   );

   cmp_out_ff u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit),
      .act   (act_mode),
      .lvl   (edge_pol),
      .pin   (pin_out)
   );

   // R1: reset leaves the first post-reset cycle quiet
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> !flag && !pin_out);

endmodule

// File: tb/soc_cmp_channel_test.sv
`timescale 1ns/1ps
module soc_cmp_channel_test;

   localparam int unsigned W = 4;
   localparam int unsigned N = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] cnt_bus = '0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         upd_en = 1'b0;
   logic         edge_sel = 1'b0;
   logic         edge_pol = 1'b0;
   logic         flag_clr = 1'b0;
   logic         flag;
   logic         pin_out;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   logic [W-1:0] m_stg = '0;
   logic [W-1:0] m_act = '0;
   logic         m_flag = 1'b0;
   logic         m_pin = 1'b0;

   always #2.5 clk = ~clk;

   soc_cmp_channel #(.CNT_W(W), .MATCH_STYLE(1)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_bus  (cnt_bus),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .upd_en   (upd_en),
      .edge_sel (edge_sel),
      .edge_pol (edge_pol),
      .flag_clr (flag_clr),
      .flag     (flag),
      .pin_out  (pin_out)
   );

   task automatic check(input string tag, input logic exp_f, input logic exp_p);
      tests++;
      if (flag !== exp_f || pin_out !== exp_p) begin
         fails++;
         $display("FAIL %s: flag=%b pin=%b expected flag=%b pin=%b (cnt=%0d)",
                  tag, flag, pin_out, exp_f, exp_p, cnt_bus);
      end
   endtask

   // one clock: update the reference model from the requirements, then compare
   task automatic step(input string tag);
      logic hit;
      @(posedge clk);
      hit = (cnt_bus == m_act);
      m_flag = hit | (m_flag & ~flag_clr);
      if (hit) m_pin = edge_sel ? ~m_pin : edge_pol;
      if (upd_en) m_act = m_stg;
      if (wr_en) m_stg = wr_data;
      #1;
      check(tag, m_flag, m_pin);
   endtask

   initial begin
      // R1 reset state
      #1;
      check("R1", 1'b0, 1'b0);
      repeat (3) @(posedge clk);
      #1;
      check("R1", 1'b0, 1'b0);
      cnt_bus = 4'd5;
      rst_n = 1'b1;
      step("R1");

      // R2/R5/R7: every compare value against every counter value, toggle mode
      edge_sel = 1'b1;
      upd_en = 1'b1;
      for (int c = 0; c < N; c++) begin
         wr_en = 1'b1; wr_data = W'(c); flag_clr = 1'b1;
         cnt_bus = W'(c + 8);
         step("R7");
         wr_en = 1'b0;
         step("R7");
         for (int k = 0; k < N; k++) begin
            cnt_bus = W'(k);
            edge_pol = k[0];
            flag_clr = 1'b1;
            step("R5");
            flag_clr = 1'b0;
            cnt_bus = W'(k + 1);
            step("R2");
         end
      end

      // R4: force mode, every compare value, level alternating per pass
      edge_sel = 1'b0;
      for (int c = 0; c < N; c++) begin
         wr_en = 1'b1; wr_data = W'(N - 1 - c);
         step("R4");
         wr_en = 1'b0;
         for (int k = 0; k < N; k++) begin
            cnt_bus = W'(k);
            edge_pol = c[0] ^ k[1];
            flag_clr = k[2];
            step("R4");
         end
      end

      // R6: staged value not used while promotion disabled
      wr_en = 1'b1; wr_data = 4'd3; edge_sel = 1'b1;
      step("R6");
      wr_en = 1'b0;
      step("R6");
      upd_en = 1'b0;
      wr_en = 1'b1; wr_data = 4'd9;
      step("R6");
      wr_en = 1'b0;
      for (int lap = 0; lap < 3; lap++) begin
         for (int k = 0; k < N; k++) begin
            cnt_bus = W'(k);
            flag_clr = 1'b1;
            step("R6");
         end
      end
      // R7: promotion once enabled
      upd_en = 1'b1;
      for (int k = 0; k < 2 * N; k++) begin
         cnt_bus = W'(k);
         flag_clr = (k[1:0] == 2'b11);
         step("R7");
      end

      // R3: free-running counter, clear once per lap
      wr_en = 1'b1; wr_data = 4'd11;
      step("R3");
      wr_en = 1'b0;
      for (int k = 0; k < 5 * N; k++) begin
         cnt_bus = W'(k);
         flag_clr = (W'(k) == 4'd0);
         step("R3");
      end

      // R8: sticky flag, clear alone, clear colliding with match
      flag_clr = 1'b0; cnt_bus = 4'd11;
      step("R8");
      cnt_bus = 4'd2;
      for (int k = 0; k < 6; k++) step("R8");
      flag_clr = 1'b1; cnt_bus = 4'd11;
      step("R8");
      cnt_bus = 4'd4;
      step("R8");
      flag_clr = 1'b0;
      step("R8");

      // R9: no match in either mode, level wiggling
      for (int k = 0; k < 20; k++) begin
         edge_sel = k[0];
         edge_pol = k[1];
         cnt_bus = (k[2]) ? 4'd1 : 4'd7;
         step("R9");
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule